// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host processor access to a bank of 8-bit registers that sits behind a narrow, slow back-end port. The host never addresses those registers directly. It places a command in a 32-bit command word: a back-end register address, a direction bit, byte-enable bits and a size bit. It moves the byte through a data word, then polls a busy bit until the transfer has finished. A write is launched by the data-word write. A read is launched by the command-word write itself, and the fetched byte then appears in the data word.

The back end is a synchronous request/response port. A request is held with valid until the far side raises ready. A one-cycle response pulse follows after any number of cycles, and it carries the read byte. Only one request is ever outstanding. The block also gathers two interrupt sources into one output line. Bit 0 is transfer completion in the bridge. Bit 1 is a rising edge on an event line from the back-end subsystem. Each source has its own enable bit and its own write-one-to-clear flag bit.

Top module: `indirect_reg_bridge`

## Requirements
- R1: After reset every host register reads zero and irq is low, except offset 0x00. Offset 0x00 is a read-only identifier that reads the parameter ID_VALUE (default 32'h49524201).
- R2: A host write to the lower data word (offset 0x08) starts a back-end write when all of these hold: busy is low, command bit 16 (lowest-byte enable) is 1, and command bit 24 (direction) is 0. The write goes to address command[7:0] and carries data bits 7:0. Command bit 31 (busy) reads 1 from the next cycle and falls in the cycle after the response.
- R3: A host write to the command word (offset 0x04) starts a back-end read of address wdata[7:0] when busy is low and the written value has bit 24 = 1 and bit 16 = 1. When the response arrives, its byte is stored in lower data bits 7:0. Lower data bits 31:8 always read zero.
- R4: A back-end request holds its valid, address, direction and data stable until ready is seen. No second request is issued before the response to the first has arrived.
- R5: Host writes to the command word or the lower data word are ignored while busy is 1. The stored command, the stored data and the back-end traffic are unchanged.
- R6: A write to the lower data word stores the value but starts nothing when command bit 16 is 0 or command bit 24 is 1. A command write starts nothing unless it has both bit 24 and bit 16 set.
- R7: The upper data word (offset 0x0C) is a plain 32-bit read/write register. Writing it never starts a transfer.
- R8: The interrupt enable register (offset 0x10) keeps bits 1:0 as written, and its bits 31:2 read zero.
- R9: The interrupt flag register (offset 0x14) sets bit 0 when a transfer completes. It sets bit 1 on a rising edge of sub_event, and a level that stays high does not set it again. Writing 1 to a flag bit clears it. A set that falls in the same cycle as a clear wins.
- R10: irq is high exactly when some flag bit and its enable bit are both 1.
- R11: The command word reads back its bits 25:16 and 7:0 as last accepted. Bit 31 shows busy, and all other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Byte offset of the host register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational, zero when no read |
| be_req_valid | output | 1 | Back-end request valid |
| be_req_ready | input | 1 | Back-end accepts request |
| be_req_write | output | 1 | 1 = write request, 0 = read request |
| be_req_addr | output | 8 | Back-end register address |
| be_req_wdata | output | 8 | Back-end write byte |
| be_rsp_valid | input | 1 | One-cycle response pulse |
| be_rsp_rdata | input | 8 | Read byte, valid with the response pulse |
| sub_event | input | 1 | Event line from the back-end subsystem |
| irq | output | 1 | Aggregated interrupt |

## Verification
The bound checker checks the back-end handshake on every cycle. It checks that a request stays stable while ready is low, that a request never appears without busy, and that completion drops busy one cycle later. It also checks that completion and event edges raise their flags, that an enabled event edge raises irq, and that the upper bits of the lower data word read zero. Some behaviours are only visible across a sequence of host accesses, so only the bench scenarios can show them. These are the ignoring of command and data writes while busy, the conditions under which a write stores data but launches nothing, the set-over-clear priority, and the correct byte landing in the back-end register or the data word.

// File: rtl/irb_pkg.sv
package irb_pkg;

  localparam int HADDR_W = 5;
  localparam int HDATA_W = 32;
  localparam int NUM_IRQ = 2;

  localparam logic [HADDR_W-1:0] OFS_ID    = 5'h00;
  localparam logic [HADDR_W-1:0] OFS_CMD   = 5'h04;
  localparam logic [HADDR_W-1:0] OFS_LDATA = 5'h08;
  localparam logic [HADDR_W-1:0] OFS_UDATA = 5'h0C;
  localparam logic [HADDR_W-1:0] OFS_IEN   = 5'h10;
  localparam logic [HADDR_W-1:0] OFS_IFLG  = 5'h14;

  localparam int CMD_BUSY   = 31;
  localparam int CMD_DIR    = 24;
  localparam int CMD_BEN_LO = 16;

  localparam int IRQ_XFER = 0;
  localparam int IRQ_SUB  = 1;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_REQ  = 2'd1,
    XS_WAIT = 2'd2
  } xfer_state_e;

  // Writable part of the command word: bits 25:16 plus the address field.
  function automatic logic [HDATA_W-1:0] cmd_wmask(input int addr_w);
    return (32'h0000_03FF << 16) | ((32'h1 << addr_w) - 32'h1);
  endfunction

  // Next flag value: write-one-to-clear, with set taking priority.
  function automatic logic [NUM_IRQ-1:0] flag_next(input logic [NUM_IRQ-1:0] cur,
                                                   input logic [NUM_IRQ-1:0] set,
                                                   input logic [NUM_IRQ-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic irq_any(input logic [NUM_IRQ-1:0] flg,
                                   input logic [NUM_IRQ-1:0] en);
    return |(flg & en);
  endfunction

endpackage

// File: rtl/irb_xfer_fsm.sv
module irb_xfer_fsm
  import irb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  output logic              be_req_valid,
  input  logic              be_req_ready,
  output logic              be_req_write,
  output logic [ADDR_W-1:0] be_req_addr,
  output logic [DATA_W-1:0] be_req_wdata,
  input  logic              be_rsp_valid,
  input  logic [DATA_W-1:0] be_rsp_rdata,
  output logic              busy,
  output logic              done,
  output logic              rd_capture,
  output logic [DATA_W-1:0] rd_data
);

  xfer_state_e       state_q;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (state_q)
        XS_IDLE: if (start) begin
          state_q <= XS_REQ;
          write_q <= start_write;
          addr_q  <= start_addr;
          wdata_q <= start_wdata;
        end
        XS_REQ:  if (be_req_ready) state_q <= XS_WAIT;
        XS_WAIT: if (be_rsp_valid) state_q <= XS_IDLE;
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign be_req_valid = (state_q == XS_REQ);
  assign be_req_write = write_q;
  assign be_req_addr  = addr_q;
  assign be_req_wdata = wdata_q;
  assign busy         = (state_q != XS_IDLE);
  assign done         = (state_q == XS_WAIT) && be_rsp_valid;
  assign rd_capture   = done && !write_q;
  assign rd_data      = be_rsp_rdata;

endmodule

// File: rtl/irb_irq_ctrl.sv
module irb_irq_ctrl
  import irb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ien_we,
  input  logic               flg_we,
  input  logic [NUM_IRQ-1:0] wbits,
  input  logic               xfer_done,
  input  logic               sub_event,
  output logic [NUM_IRQ-1:0] ien_q,
  output logic [NUM_IRQ-1:0] iflg_q,
  output logic               evt_rise,
  output logic               irq
);

  logic               sub_event_d;
  logic [NUM_IRQ-1:0] set_vec;
  logic [NUM_IRQ-1:0] clr_vec;

  assign evt_rise = sub_event && !sub_event_d;

  always_comb begin
    set_vec           = '0;
    set_vec[IRQ_XFER] = xfer_done;
    set_vec[IRQ_SUB]  = evt_rise;
    clr_vec           = flg_we ? wbits : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_event_d <= 1'b0;
      ien_q       <= '0;
      iflg_q      <= '0;
    end else begin
      sub_event_d <= sub_event;
      if (ien_we) ien_q <= wbits;
      iflg_q <= flag_next(iflg_q, set_vec, clr_vec);
    end
  end

  assign irq = irq_any(iflg_q, ien_q);

endmodule

// File: rtl/irb_host_regs.sv
module irb_host_regs
  import irb_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter int               DATA_W   = 8,
  parameter logic [HDATA_W-1:0] ID_VALUE = 32'h4952_4201
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sel,
  input  logic               host_wr,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [HDATA_W-1:0] host_wdata,
  output logic [HDATA_W-1:0] host_rdata,
  input  logic               busy,
  input  logic               rd_capture,
  input  logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_IRQ-1:0] ien_q,
  input  logic [NUM_IRQ-1:0] iflg_q,
  output logic               start,
  output logic               start_write,
  output logic [ADDR_W-1:0]  start_addr,
  output logic [DATA_W-1:0]  start_wdata,
  output logic               ien_we,
  output logic               flg_we
);

  localparam logic [HDATA_W-1:0] CMD_MASK = cmd_wmask(ADDR_W);

  logic [HDATA_W-1:0] cmd_q;
  logic [DATA_W-1:0]  ldata_q;
  logic [HDATA_W-1:0] udata_q;
  logic               host_we;
  logic               cmd_we;
  logic               ldata_we;
  logic               udata_we;
  logic               go_write;
  logic               go_read;

  assign host_we  = host_sel && host_wr;
  assign cmd_we   = host_we && (host_addr == OFS_CMD)   && !busy;
  assign ldata_we = host_we && (host_addr == OFS_LDATA) && !busy;
  assign udata_we = host_we && (host_addr == OFS_UDATA);
  assign ien_we   = host_we && (host_addr == OFS_IEN);
  assign flg_we   = host_we && (host_addr == OFS_IFLG);

  assign go_write = ldata_we && cmd_q[CMD_BEN_LO] && !cmd_q[CMD_DIR];
  assign go_read  = cmd_we && host_wdata[CMD_BEN_LO] && host_wdata[CMD_DIR];

  assign start       = go_write || go_read;
  assign start_write = go_write;
  assign start_addr  = go_read ? host_wdata[ADDR_W-1:0] : cmd_q[ADDR_W-1:0];
  assign start_wdata = host_wdata[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      ldata_q <= '0;
      udata_q <= '0;
    end else begin
      if (cmd_we)        cmd_q   <= host_wdata & CMD_MASK;
      if (ldata_we)      ldata_q <= host_wdata[DATA_W-1:0];
      else if (rd_capture) ldata_q <= rd_data;
      if (udata_we)      udata_q <= host_wdata;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_sel && !host_wr) begin
      case (host_addr)
        OFS_ID:    host_rdata = ID_VALUE;
        OFS_CMD:   host_rdata = {busy, cmd_q[HDATA_W-2:0]};
        OFS_LDATA: host_rdata = {{(HDATA_W-DATA_W){1'b0}}, ldata_q};
        OFS_UDATA: host_rdata = udata_q;
        OFS_IEN:   host_rdata = {{(HDATA_W-NUM_IRQ){1'b0}}, ien_q};
        OFS_IFLG:  host_rdata = {{(HDATA_W-NUM_IRQ){1'b0}}, iflg_q};
        default:   host_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/indirect_reg_bridge.sv
module indirect_reg_bridge
  import irb_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter int               DATA_W   = 8,
  parameter logic [31:0]      ID_VALUE = 32'h4952_4201
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [4:0]        host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              be_req_valid,
  input  logic              be_req_ready,
  output logic              be_req_write,
  output logic [ADDR_W-1:0] be_req_addr,
  output logic [DATA_W-1:0] be_req_wdata,
  input  logic              be_rsp_valid,
  input  logic [DATA_W-1:0] be_rsp_rdata,
  input  logic              sub_event,
  output logic              irq
);

  logic               xfer_busy;
  logic               xfer_done;
  logic               rd_capture;
  logic [DATA_W-1:0]  rd_data;
  logic               start;
  logic               start_write;
  logic [ADDR_W-1:0]  start_addr;
  logic [DATA_W-1:0]  start_wdata;
  logic               ien_we;
  logic               flg_we;
  logic [NUM_IRQ-1:0] ien_q;
  logic [NUM_IRQ-1:0] iflg_q;
  logic               evt_rise;

  irb_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(xfer_busy), .rd_capture(rd_capture), .rd_data(rd_data),
    .ien_q(ien_q), .iflg_q(iflg_q),
    .start(start), .start_write(start_write), .start_addr(start_addr),
    .start_wdata(start_wdata), .ien_we(ien_we), .flg_we(flg_we)
  );

  irb_xfer_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_write(start_write), .start_addr(start_addr),
    .start_wdata(start_wdata),
    .be_req_valid(be_req_valid), .be_req_ready(be_req_ready),
    .be_req_write(be_req_write), .be_req_addr(be_req_addr),
    .be_req_wdata(be_req_wdata), .be_rsp_valid(be_rsp_valid),
    .be_rsp_rdata(be_rsp_rdata),
    .busy(xfer_busy), .done(xfer_done), .rd_capture(rd_capture), .rd_data(rd_data)
  );

  irb_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n),
    .ien_we(ien_we), .flg_we(flg_we), .wbits(host_wdata[NUM_IRQ-1:0]),
    .xfer_done(xfer_done), .sub_event(sub_event),
    .ien_q(ien_q), .iflg_q(iflg_q), .evt_rise(evt_rise), .irq(irq)
  );

endmodule

// File: rtl/irb_checker.sv
module irb_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_sel,
  input logic              host_wr,
  input logic [4:0]        host_addr,
  input logic [31:0]       host_rdata,
  input logic              be_req_valid,
  input logic              be_req_ready,
  input logic              be_req_write,
  input logic [ADDR_W-1:0] be_req_addr,
  input logic [DATA_W-1:0] be_req_wdata,
  input logic              xfer_busy,
  input logic              xfer_done,
  input logic              evt_rise,
  input logic [1:0]        ien_q,
  input logic [1:0]        iflg_q,
  input logic              irq
);

  logic ien_write;
  assign ien_write = host_sel && host_wr && (host_addr == 5'h10);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    be_req_valid && !be_req_ready |=> be_req_valid && $stable(be_req_addr)
      && $stable(be_req_write) && $stable(be_req_wdata));

  p_req_needs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    be_req_valid |-> xfer_busy);

  p_done_drops_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_busy);

  p_no_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_busy |-> !xfer_done);

  p_done_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> iflg_q[0]);

  p_event_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rise |=> iflg_q[1]);

  p_event_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rise && ien_q[1] && !ien_write |=> irq);

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 2'b00) |-> !irq);

  p_ldata_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel && !host_wr && (host_addr == 5'h08) |-> (host_rdata[31:DATA_W] == '0));

endmodule

bind indirect_reg_bridge irb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_irb_checker (
  .clk(clk), .rst_n(rst_n),
  .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr), .host_rdata(host_rdata),
  .be_req_valid(be_req_valid), .be_req_ready(be_req_ready),
  .be_req_write(be_req_write), .be_req_addr(be_req_addr), .be_req_wdata(be_req_wdata),
  .xfer_busy(xfer_busy), .xfer_done(xfer_done), .evt_rise(evt_rise),
  .ien_q(ien_q), .iflg_q(iflg_q), .irq(irq)
);

// File: tb/indirect_reg_bridge_bench.sv
`timescale 1ns/1ps
module indirect_reg_bridge_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0;
  logic        host_wr = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        be_req_valid;
  logic        be_req_ready;
  logic        be_req_write;
  logic [7:0]  be_req_addr;
  logic [7:0]  be_req_wdata;
  logic        be_rsp_valid = 1'b0;
  logic [7:0]  be_rsp_rdata = '0;
  logic        sub_event = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  indirect_reg_bridge u_indirect_reg_bridge (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .be_req_valid(be_req_valid), .be_req_ready(be_req_ready),
    .be_req_write(be_req_write), .be_req_addr(be_req_addr),
    .be_req_wdata(be_req_wdata), .be_rsp_valid(be_rsp_valid),
    .be_rsp_rdata(be_rsp_rdata), .sub_event(sub_event), .irq(irq)
  );

  // Back-end model: programmable accept stall and response latency.
  logic [7:0] mem [256];
  logic [7:0] stall_cfg = 8'd0;
  logic [7:0] lat_cfg = 8'd2;
  logic [7:0] stall_q;
  logic [7:0] hold_q;
  logic [7:0] taddr_q;
  int         n_req = 0;

  assign be_req_ready = (stall_q == 8'd0);

  always @(posedge clk) begin
    be_rsp_valid <= 1'b0;
    if (!rst_n) begin
      stall_q <= stall_cfg;
      hold_q  <= 8'd0;
      taddr_q <= 8'd0;
    end else begin
      if (hold_q != 8'd0) begin
        hold_q <= hold_q - 8'd1;
        if (hold_q == 8'd1) begin
          be_rsp_valid <= 1'b1;
          be_rsp_rdata <= mem[taddr_q];
        end
      end
      if (be_req_valid && be_req_ready) begin
        if (be_req_write) mem[be_req_addr] <= be_req_wdata;
        taddr_q <= be_req_addr;
        hold_q  <= lat_cfg;
        n_req   <= n_req + 1;
        stall_q <= stall_cfg;
      end else if (!be_req_valid) begin
        stall_q <= stall_cfg;
      end else if (stall_q != 8'd0) begin
        stall_q <= stall_q - 8'd1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
    #1 d = host_rdata;
    host_sel = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      host_read(5'h04, v);
      if (!v[31]) return;
    end
    check("R2 busy never cleared", 32'd1, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    host_read(5'h00, v); check("R1 id", v, 32'h4952_4201);
    host_read(5'h04, v); check("R1 cmd", v, 32'h0);
    host_read(5'h08, v); check("R1 ldata", v, 32'h0);
    host_read(5'h0C, v); check("R1 udata", v, 32'h0);
    host_read(5'h10, v); check("R1 ien", v, 32'h0);
    host_read(5'h14, v); check("R1 iflg", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_write_xfer();
    logic [31:0] v;
    int n0 = n_req;
    stall_cfg = 8'd3; lat_cfg = 8'd4;
    host_write(5'h04, 32'h0001_0021);
    host_write(5'h08, 32'hFFFF_FF6C);
    host_read(5'h04, v); check("R2 busy high after data write", {31'b0, v[31]}, 32'h1);
    wait_idle();
    check("R2 one write request", n_req - n0, 1);
    check("R2 byte written at address", {24'b0, mem[8'h21]}, 32'h6C);
    host_read(5'h08, v); check("R3 ldata upper zero", v, 32'h6C);
  endtask

  task automatic t_read_xfer();
    logic [31:0] v;
    stall_cfg = 8'd0; lat_cfg = 8'd1;
    host_write(5'h04, 32'h0101_0042);
    wait_idle();
    host_read(5'h08, v); check("R3 read byte in ldata", v, {24'b0, 8'h42 ^ 8'hA5});
    stall_cfg = 8'd2; lat_cfg = 8'd5;
    host_write(5'h04, 32'hFFFF_FFFF);
    host_read(5'h04, v); check("R11 cmd readback while busy", v, 32'h83FF_00FF);
    wait_idle();
    host_read(5'h04, v); check("R11 cmd readback idle", v, 32'h03FF_00FF);
    host_read(5'h08, v); check("R3 read addr ff", v, {24'b0, 8'hFF ^ 8'hA5});
  endtask

  task automatic t_ignore_busy();
    logic [31:0] v;
    int n0;
    host_write(5'h04, 32'h0001_0033);
    n0 = n_req;
    stall_cfg = 8'd20; lat_cfg = 8'd3;
    host_write(5'h08, 32'h0000_005A);
    host_write(5'h04, 32'h0101_0044);
    host_write(5'h08, 32'h0000_0099);
    wait_idle();
    host_read(5'h04, v); check("R5 cmd unchanged", v, 32'h0001_0033);
    host_read(5'h08, v); check("R5 ldata unchanged", v, 32'h5A);
    check("R5 single request", n_req - n0, 1);
    check("R5 byte written", {24'b0, mem[8'h33]}, 32'h5A);
    check("R4 no write to 0x44", {24'b0, mem[8'h44]}, {24'b0, 8'h44 ^ 8'hA5});
  endtask

  task automatic t_no_start();
    logic [31:0] v;
    int n0 = n_req;
    host_write(5'h04, 32'h0000_0010);
    host_write(5'h08, 32'h0000_0123);
    host_read(5'h04, v); check("R6 no busy ben clear", {31'b0, v[31]}, 32'h0);
    host_read(5'h08, v); check("R6 ldata stored", v, 32'h23);
    host_write(5'h04, 32'h0100_0010);
    host_write(5'h08, 32'h0000_0077);
    host_write(5'h04, 32'h0001_0010);
    host_read(5'h04, v); check("R6 cmd dir0 no start", v, 32'h0001_0010);
    host_write(5'h0C, 32'hDEAD_BEEF);
    host_read(5'h0C, v); check("R7 udata", v, 32'hDEAD_BEEF);
    check("R6 R7 no requests", n_req - n0, 0);
    check("R6 mem untouched", {24'b0, mem[8'h10]}, {24'b0, 8'h10 ^ 8'hA5});
  endtask

  task automatic t_irq();
    logic [31:0] v;
    host_write(5'h10, 32'hFFFF_FFFE);
    host_read(5'h10, v); check("R8 ien bits", v, 32'h2);
    host_read(5'h14, v); check("R9 done flag set", v, 32'h1);
    check("R10 irq off flag0 masked", {31'b0, irq}, 32'h0);
    host_write(5'h14, 32'h1);
    host_read(5'h14, v); check("R9 w1c bit0", v, 32'h0);
    @(negedge clk); sub_event = 1'b1;
    @(negedge clk);
    host_read(5'h14, v); check("R9 event edge flag", v, 32'h2);
    check("R10 irq on", {31'b0, irq}, 32'h1);
    host_write(5'h14, 32'h2);
    host_read(5'h14, v); check("R9 level no reset", v, 32'h0);
    check("R10 irq off", {31'b0, irq}, 32'h0);
    @(negedge clk); sub_event = 1'b0;
    @(negedge clk);
    sub_event = 1'b1;
    host_sel = 1'b1; host_wr = 1'b1; host_addr = 5'h14; host_wdata = 32'h2;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
    host_read(5'h14, v); check("R9 set wins over clear", v, 32'h2);
    sub_event = 1'b0;
    host_write(5'h14, 32'h3);
    host_read(5'h14, v); check("R9 clear all", v, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_xfer();
    t_read_xfer();
    t_ignore_busy();
    t_no_start();
    t_irq();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule